// File: doc/BRIEF.md
# Panel Power Management Timer

This block is the inactivity timer of a flat-panel display controller. It counts idle time in quarter-minute steps. When no enabled activity has been seen for a programmed time, it moves the panel from ACTIVE to STANDBY and later to OFF. Two strobes report activity: display accesses (memory or register) and keyboard events. Each strobe can be enabled on its own to restart the panel state timer, the backlight timer, or both.

The time base is a 32 kHz-rate pulse. It is either produced inside the block by dividing a fast oscillator pulse (nominally derived from 14.318 MHz) or taken directly from an external 32 kHz pulse. In OFF state the block can take over memory refresh and produce it at a slow rate of 32, 16 or 8 kHz. It also drives the backlight enable, which software can force to a level or invert, and the panel supply enable, which software can force on. Software writes four control bytes through a simple write port.

Top module: `ppm_top`

Register map (`cfg_addr`, all bytes reset to 0x00):
- 0 wake sources: bit0 display→backlight timer, bit1 keyboard→backlight timer, bit2 display→state timer, bit3 keyboard→state timer.
- 1 delays: bits[3:0] standby time in minutes, bits[7:4] backlight time in minutes (0 = never expires).
- 2 off/refresh: bits[3:0] off time in 4-minute units (0 = never), bit4 slow refresh enable, bits[6:5] rate code, bit7 clock base select.
- 3 overrides: bit0 backlight override, bit1 backlight level/polarity, bit2 panel supply force-on.

## Requirements
- R1: After reset, pm_state is ACTIVE (code 0; STANDBY is 1 and OFF is 2, and 3 never appears), backlight is 1, panel_pwr is 1, and slow_ref_mode and slow_ref_tick are 0.
- R2: With a nonzero standby time S (address 1, bits[3:0]), pm_state becomes STANDBY once 4·S quarter-minute ticks have passed without enabled state-timer activity. With S = 0 it never enters STANDBY.
- R3: With a nonzero off code F (address 2, bits[3:0]), pm_state becomes OFF once 16·F quarter-minute ticks have passed without enabled state-timer activity. With F = 0 it never enters OFF.
- R4: A display strobe with address 0 bit2 set, or a keyboard strobe with bit3 set, clears the state idle count and returns pm_state to ACTIVE within two cycles. A strobe whose enable bit is clear has no effect on pm_state.
- R5: With a nonzero backlight time B (address 1, bits[7:4]), the normal backlight level drops to 0 after 4·B quarter ticks without enabled backlight activity (address 0 bit0 display, bit1 keyboard). It is also 0 in OFF state, and with B = 0 it stays 1 outside OFF.
- R6: With address 2 bit7 = 1, each ext_tick is one base tick. With bit7 = 0, base ticks come from every OSC_DIV-th osc_tick, and ext_tick is ignored. QTR_DIV base ticks make one quarter-minute tick.
- R7: In OFF state with address 2 bit4 set, slow_ref_mode is 1, and slow_ref_tick pulses on every base tick for rate code 01, on every 2nd for 10, on every 4th for 11, and never for 00. Otherwise both outputs are 0.
- R8: With address 3 bit0 = 1, backlight equals bit1. With bit0 = 0, backlight is the normal level XOR bit1.
- R9: panel_pwr is 0 only in OFF state with address 3 bit2 clear.
- R10: Idle counts saturate and do not wrap. After a long idle period, setting an off time below the elapsed time enters OFF at once.
- R11: Activity does not restart the quarter-minute prescaler, so a programmed delay may expire up to one quarter minute early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_addr | input | 2 | Control byte select |
| cfg_wdata | input | 8 | Control byte value |
| disp_act | input | 1 | Display access activity strobe |
| kbd_act | input | 1 | Keyboard activity strobe |
| osc_tick | input | 1 | Fast oscillator pulse, one cycle per period |
| ext_tick | input | 1 | External 32 kHz pulse, one cycle per period |
| pm_state | output | 2 | Panel power state code |
| backlight | output | 1 | Backlight enable |
| panel_pwr | output | 1 | Panel supply enable |
| slow_ref_mode | output | 1 | Block owns refresh at the slow rate |
| slow_ref_tick | output | 1 | Slow refresh request pulse |

## Verification
The idle timers are run from both clock bases with pulse counts just below and exactly at each threshold, so an off-by-one quarter, a wrong unit multiplier or a wrong clock select shows up as a wrong state. Activity strobes are applied with their enable bits both clear and set, to show that disabled sources are ignored and enabled ones wake the panel. The state timer and the backlight timer are enabled separately so that each one's timing can be seen. Refresh pulses are counted over a fixed window of eight base ticks for every rate code and with the enable clear. A long idle run followed by a smaller off time shows whether the idle count saturates. An activity strobe placed at an odd prescaler phase shows that the prescaler keeps running through activity.

// File: rtl/ppm_pkg.sv
package ppm_pkg;
   typedef enum logic [1:0] {
      PM_ACTIVE  = 2'd0,
      PM_STANDBY = 2'd1,
      PM_OFF     = 2'd2
   } pm_state_e;

   localparam logic [1:0] ADDR_WAKE  = 2'd0;
   localparam logic [1:0] ADDR_DELAY = 2'd1;
   localparam logic [1:0] ADDR_OFFC  = 2'd2;
   localparam logic [1:0] ADDR_OVR   = 2'd3;

   localparam logic [1:0] RATE_NONE = 2'b00;
   localparam logic [1:0] RATE_32K  = 2'b01;
   localparam logic [1:0] RATE_16K  = 2'b10;
   localparam logic [1:0] RATE_8K   = 2'b11;
endpackage

// File: rtl/ppm_div.sv
module ppm_div #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_pulse,
   output logic out_pulse
);
   generate
      if (DIV < 1) begin : g_bad
         $error("ppm_div: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_pass
         assign out_pulse = in_pulse;
      end else begin : g_cnt
         localparam int CW = $clog2(DIV);
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (in_pulse)
               cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
         end
         assign out_pulse = in_pulse && (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/ppm_timebase.sv
module ppm_timebase #(
   parameter int OSC_DIV = 437,
   parameter int QTR_DIV = 491520
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_tick,
   input  logic ext_tick,
   input  logic ext_sel,
   output logic base_tick,
   output logic qtr_tick
);
   logic osc_base;

   ppm_div #(.DIV(OSC_DIV)) u_osc_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_pulse (osc_tick),
      .out_pulse(osc_base)
   );

   assign base_tick = ext_sel ? ext_tick : osc_base;

   ppm_div #(.DIV(QTR_DIV)) u_qtr_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_pulse (base_tick),
      .out_pulse(qtr_tick)
   );
endmodule

// File: rtl/ppm_idle_ctr.sv
module ppm_idle_ctr #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         adv,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (adv && (cnt != TOP))
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/ppm_top.sv
module ppm_top
   import ppm_pkg::*;
#(
   parameter int OSC_DIV     = 437,
   parameter int QTR_DIV     = 491520,
   parameter int QTR_PER_MIN = 4,
   parameter int OFF_MIN     = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_we,
   input  logic [1:0] cfg_addr,
   input  logic [7:0] cfg_wdata,
   input  logic       disp_act,
   input  logic       kbd_act,
   input  logic       osc_tick,
   input  logic       ext_tick,
   output logic [1:0] pm_state,
   output logic       backlight,
   output logic       panel_pwr,
   output logic       slow_ref_mode,
   output logic       slow_ref_tick
);
   localparam int MAX_LIM = 15 * QTR_PER_MIN * OFF_MIN;
   localparam int CNT_W   = $clog2(MAX_LIM + 1);

   generate
      if (QTR_PER_MIN < 1) begin : g_bad_qpm
         $error("ppm_top: QTR_PER_MIN must be at least 1");
      end
      if (OFF_MIN < 1) begin : g_bad_off
         $error("ppm_top: OFF_MIN must be at least 1");
      end
   endgenerate

   logic [3:0] r_wake;
   logic [7:0] r_dly;
   logic [7:0] r_offc;
   logic [2:0] r_ovr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_wake <= '0;
         r_dly  <= '0;
         r_offc <= '0;
         r_ovr  <= '0;
      end else if (cfg_we) begin
         case (cfg_addr)
            ADDR_WAKE:  r_wake <= cfg_wdata[3:0];
            ADDR_DELAY: r_dly  <= cfg_wdata;
            ADDR_OFFC:  r_offc <= cfg_wdata;
            default:    r_ovr  <= cfg_wdata[2:0];
         endcase
      end
   end

   logic [3:0] stby_code, bl_code, off_code;
   logic       ref_en, ext_sel;
   logic [1:0] ref_rate;
   assign stby_code = r_dly[3:0];
   assign bl_code   = r_dly[7:4];
   assign off_code  = r_offc[3:0];
   assign ref_en    = r_offc[4];
   assign ref_rate  = r_offc[6:5];
   assign ext_sel   = r_offc[7];

   logic base_tick, qtr_tick;
   ppm_timebase #(.OSC_DIV(OSC_DIV), .QTR_DIV(QTR_DIV)) u_tb (
      .clk      (clk),
      .rst_n    (rst_n),
      .osc_tick (osc_tick),
      .ext_tick (ext_tick),
      .ext_sel  (ext_sel),
      .base_tick(base_tick),
      .qtr_tick (qtr_tick)
   );

   logic [1:0] clr_vec;
   logic [CNT_W-1:0] cnt_arr [2];
   assign clr_vec[0] = (r_wake[2] & disp_act) | (r_wake[3] & kbd_act);
   assign clr_vec[1] = (r_wake[0] & disp_act) | (r_wake[1] & kbd_act);

   generate
      for (genvar gi = 0; gi < 2; gi++) begin : g_idle
         ppm_idle_ctr #(.W(CNT_W)) u_ctr (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (clr_vec[gi]),
            .adv  (qtr_tick),
            .cnt  (cnt_arr[gi])
         );
      end
   endgenerate

   logic [CNT_W-1:0] stby_lim, off_lim, bl_lim;
   assign stby_lim = CNT_W'(stby_code) * CNT_W'(QTR_PER_MIN);
   assign bl_lim   = CNT_W'(bl_code)   * CNT_W'(QTR_PER_MIN);
   assign off_lim  = CNT_W'(off_code)  * CNT_W'(QTR_PER_MIN * OFF_MIN);

   pm_state_e st_q, st_d;
   always_comb begin
      if ((off_code != 4'd0) && (cnt_arr[0] >= off_lim))
         st_d = PM_OFF;
      else if ((stby_code != 4'd0) && (cnt_arr[0] >= stby_lim))
         st_d = PM_STANDBY;
      else
         st_d = PM_ACTIVE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= PM_ACTIVE;
      else        st_q <= st_d;
   end
   assign pm_state = st_q;

   logic bl_run, bl_norm;
   assign bl_run    = (bl_code == 4'd0) || (cnt_arr[1] < bl_lim);
   assign bl_norm   = bl_run && (st_q != PM_OFF);
   assign backlight = r_ovr[0] ? r_ovr[1] : (bl_norm ^ r_ovr[1]);
   assign panel_pwr = r_ovr[2] | (st_q != PM_OFF);

   logic [1:0] rdiv_q;
   logic       rate_hit, slow_on;
   always_comb begin
      case (ref_rate)
         RATE_32K: rate_hit = 1'b1;
         RATE_16K: rate_hit = (rdiv_q[0] == 1'b0);
         RATE_8K:  rate_hit = (rdiv_q == 2'd0);
         default:  rate_hit = 1'b0;
      endcase
   end
   assign slow_on = ref_en && (st_q == PM_OFF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdiv_q        <= '0;
         slow_ref_mode <= 1'b0;
         slow_ref_tick <= 1'b0;
      end else begin
         if (base_tick) rdiv_q <= rdiv_q + 1'b1;
         slow_ref_mode <= slow_on;
         slow_ref_tick <= slow_on && base_tick && rate_hit;
      end
   end
endmodule

// File: rtl/ppm_chk.sv
module ppm_chk
   import ppm_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] pm_state,
   input logic       backlight,
   input logic       panel_pwr,
   input logic       slow_ref_mode,
   input logic       slow_ref_tick,
   input logic [3:0] off_code,
   input logic       wake_hit,
   input logic       bl_ovr,
   input logic       bl_pol
);
   // R1
   state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pm_state != 2'd3);

   // R3
   off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (off_code == 4'd0 && $past(off_code) == 4'd0) |-> pm_state != PM_OFF);

   // R4
   wake_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wake_hit, 2) |-> pm_state == PM_ACTIVE);

   // R9
   supply_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_state != PM_OFF) |-> panel_pwr);

   // R7
   ref_tick_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slow_ref_tick |-> slow_ref_mode);

   // R5
   bl_dark_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_state == PM_OFF && !bl_ovr && !bl_pol) |-> !backlight);
endmodule

bind ppm_top ppm_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .pm_state     (pm_state),
   .backlight    (backlight),
   .panel_pwr    (panel_pwr),
   .slow_ref_mode(slow_ref_mode),
   .slow_ref_tick(slow_ref_tick),
   .off_code     (r_offc[3:0]),
   .wake_hit     (clr_vec[0]),
   .bl_ovr       (r_ovr[0]),
   .bl_pol       (r_ovr[1])
);

// File: tb/sim_ppm_top.sv
module sim_ppm_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [1:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic       disp_act = 1'b0;
   logic       kbd_act = 1'b0;
   logic       osc_tick = 1'b0;
   logic       ext_tick = 1'b0;
   logic [1:0] pm_state;
   logic       backlight, panel_pwr, slow_ref_mode, slow_ref_tick;

   int n_chk = 0;
   int n_bad = 0;
   int ref_cnt = 0;
   bit done = 1'b0;

   localparam int ST_ACT = 0, ST_SBY = 1, ST_OFF = 2;

   always #5 clk = ~clk;

   ppm_top #(.OSC_DIV(4), .QTR_DIV(2)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .disp_act(disp_act), .kbd_act(kbd_act),
      .osc_tick(osc_tick), .ext_tick(ext_tick), .pm_state(pm_state),
      .backlight(backlight), .panel_pwr(panel_pwr),
      .slow_ref_mode(slow_ref_mode), .slow_ref_tick(slow_ref_tick)
   );

   always @(posedge clk) if (slow_ref_tick) ref_cnt <= ref_cnt + 1;

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk); cfg_we = 1'b0;
      settle();
   endtask

   task automatic ext(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); ext_tick = 1'b1;
         @(negedge clk); ext_tick = 1'b0;
      end
      settle();
   endtask

   task automatic osc(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); osc_tick = 1'b1;
         @(negedge clk); osc_tick = 1'b0;
      end
      settle();
   endtask

   task automatic act(input bit kbd);
      @(negedge clk); if (kbd) kbd_act = 1'b1; else disp_act = 1'b1;
      @(negedge clk); kbd_act = 1'b0; disp_act = 1'b0;
      settle();
   endtask

   task automatic t_reset();
      chk("R1 state", pm_state, ST_ACT);
      chk("R1 backlight", backlight, 1);
      chk("R1 panel_pwr", panel_pwr, 1);
      chk("R1 slow_ref_mode", slow_ref_mode, 0);
      chk("R1 slow_ref_tick", slow_ref_tick, 0);
   endtask

   task automatic t_standby();
      wr(2'd0, 8'h0F);
      wr(2'd1, 8'h01);
      wr(2'd2, 8'h80);
      act(1'b0);
      ext(6);
      chk("R2 before standby time", pm_state, ST_ACT);
      ext(2);
      chk("R2 at standby time", pm_state, ST_SBY);
   endtask

   task automatic t_wake();
      wr(2'd0, 8'h03);
      act(1'b1);
      chk("R4 disabled kbd ignored", pm_state, ST_SBY);
      act(1'b0);
      chk("R4 disabled disp ignored", pm_state, ST_SBY);
      wr(2'd0, 8'h0C);
      act(1'b1);
      chk("R4 enabled kbd wakes", pm_state, ST_ACT);
      ext(8);
      chk("R2 standby again", pm_state, ST_SBY);
      act(1'b0);
      chk("R4 enabled disp wakes", pm_state, ST_ACT);
   endtask

   task automatic t_off();
      wr(2'd2, 8'h81);
      ext(30);
      chk("R3 before off time", pm_state, ST_SBY);
      ext(2);
      chk("R3 at off time", pm_state, ST_OFF);
      chk("R9 supply off", panel_pwr, 0);
      chk("R5 backlight dark in off", backlight, 0);
      wr(2'd3, 8'h04);
      chk("R9 supply forced", panel_pwr, 1);
      wr(2'd3, 8'h00);
      chk("R9 force released", panel_pwr, 0);
   endtask

   task automatic ref_window(input logic [7:0] offc, input int exp_mode,
                             input int exp_cnt, input string tag);
      int start;
      wr(2'd2, offc);
      chk({tag, " mode"}, slow_ref_mode, exp_mode);
      start = ref_cnt;
      ext(8);
      chk({tag, " pulses"}, ref_cnt - start, exp_cnt);
   endtask

   task automatic t_refresh();
      ref_window(8'hB1, 1, 8, "R7 rate 01");
      ref_window(8'hD1, 1, 4, "R7 rate 10");
      ref_window(8'hF1, 1, 2, "R7 rate 11");
      ref_window(8'h91, 1, 0, "R7 rate 00");
      ref_window(8'hE1, 0, 0, "R7 disabled");
      chk("R7 still off", pm_state, ST_OFF);
   endtask

   task automatic t_override();
      wr(2'd3, 8'h03);
      chk("R8 forced high", backlight, 1);
      wr(2'd3, 8'h01);
      chk("R8 forced low", backlight, 0);
      wr(2'd3, 8'h02);
      chk("R8 inverted", backlight, 1);
      wr(2'd3, 8'h00);
      chk("R8 normal", backlight, 0);
   endtask

   task automatic t_saturate();
      wr(2'd2, 8'h80);
      chk("R3 zero leaves off", pm_state, ST_SBY);
      ext(600);
      chk("R3 zero never off", pm_state, ST_SBY);
      wr(2'd2, 8'h8F);
      chk("R10 saturated count enters off", pm_state, ST_OFF);
   endtask

   task automatic t_backlight();
      wr(2'd2, 8'h80);
      wr(2'd1, 8'h21);
      wr(2'd0, 8'h0F);
      act(1'b1);
      ext(14);
      chk("R5 state standby", pm_state, ST_SBY);
      chk("R5 backlight before time", backlight, 1);
      ext(2);
      chk("R5 backlight expired", backlight, 0);
      wr(2'd0, 8'h0C);
      act(1'b0);
      chk("R5 state woke", pm_state, ST_ACT);
      chk("R5 disabled source leaves dark", backlight, 0);
      wr(2'd0, 8'h01);
      act(1'b0);
      chk("R5 enabled source relights", backlight, 1);
   endtask

   task automatic t_osc();
      wr(2'd1, 8'h01);
      wr(2'd0, 8'h0C);
      wr(2'd2, 8'h00);
      act(1'b0);
      ext(20);
      chk("R6 ext ignored on osc base", pm_state, ST_ACT);
      osc(28);
      chk("R6 osc before time", pm_state, ST_ACT);
      osc(4);
      chk("R6 osc at time", pm_state, ST_SBY);
   endtask

   task automatic t_short();
      wr(2'd2, 8'h80);
      ext(1);
      act(1'b0);
      ext(5);
      chk("R11 three quarters", pm_state, ST_ACT);
      ext(2);
      chk("R11 early expiry", pm_state, ST_SBY);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      settle();
      t_reset();
      t_standby();
      t_wake();
      t_off();
      t_refresh();
      t_override();
      t_saturate();
      t_backlight();
      t_osc();
      t_short();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule